// File: doc/BRIEF.md
# Tick Counter with Compare

This block keeps a free-running tick count and a compare register. Each 64-bit register word carries one control bit in its top position. For the counter word this bit is a software-visible restriction flag. For the compare word it is an interrupt-disable flag. Both registers share one internal disable flag. Any write to either register sets that flag from bit 63 of the written word. The flag is merged back into bit 63 whenever the count is read. The value part of each register is the lower 63 bits.

The counter advances by one on every clock where the external tick enable is high. This lets the surrounding logic run it at a prescaled rate, nominally 100 MHz. A compare write arms a one-shot match. When the count reaches the armed value, the block produces a single-cycle soft-interrupt set pulse, unless the disable flag is set at that moment. The block is built in two variants. The per-core tick instance drives soft-interrupt bit 0. The system-tick instances drive bit 16.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count is zero, the disable flag is clear, no compare is armed and `softint_set` is all zero.
- R2: With `wr_en` high and `wr_sel`=0, the next clock loads `wr_data[62:0]` into the count and `wr_data[63]` into the disable flag. A count write takes precedence over an increment in the same cycle.
- R3: `rd_data[62:0]` always shows the current count, and `rd_data[63]` shows the disable flag.
- R4: On each clock with `tick_en` high and no count write, the count advances by one and wraps from 2^63-1 to 0. Without `tick_en` the count holds.
- R5: With `wr_en` high and `wr_sel`=1, the next clock stores `wr_data[62:0]` as the compare value and `wr_data[63]` as the disable flag. The compare becomes armed only if the value is nonzero and bit 63 is clear.
- R6: A cycle in which the compare is armed and the count equals the compare value is a match. The match consumes the arming. If the flag is clear, `softint_set` shows a pulse exactly one cycle later, lasting one cycle.
- R7: With parameter KIND=0 the pulse appears on `softint_set[0]`. With KIND=1 it appears on `softint_set[16]`. All other bits stay zero.
- R8: A compare write with value zero arms nothing and cancels any pending match.
- R9: A compare write with bit 63 set cancels any pending match.
- R10: A match that occurs while the disable flag is set produces no pulse and still consumes the arming, so clearing the flag later does not bring the interrupt back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 compare |
| wr_data | input | 64 | Write word; bit 63 is the control bit |
| rd_data | output | 64 | Count with disable flag in bit 63 |
| softint_set | output | 17 | One-cycle soft-interrupt set pulse vector |

## Verification
The hardest situation to reach is a match that happens while the block is disabled. The only way to get there from the ports is to arm a compare with the flag clear, then set the flag through a count write before the count reaches the compare value. The bench does exactly that. It then clears the flag with another count write and keeps ticking past the compare value, to show that the arming was consumed silently.

A second corner is counter wrap. The bench reaches it by loading a count just below 2^63 and ticking through the boundary with an irregular enable pattern.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;

    // Register selected by the write port
    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_LIMIT = 1'b1
    } reg_sel_e;

    // Soft-interrupt vector layout
    localparam int SI_W         = 17;
    localparam int TICK_SI_IDX  = 0;
    localparam int STICK_SI_IDX = 16;

    // Timer variant
    localparam int KIND_TICK  = 0;
    localparam int KIND_STICK = 1;

endpackage

// File: rtl/tick_cmp_counter.sv
module tick_cmp_counter #(
    parameter int VAL_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ld_en,
    input  logic [VAL_W-1:0] ld_val,
    output logic [VAL_W-1:0] cnt
);
    localparam logic [VAL_W-1:0] ONE = {{(VAL_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [VAL_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_en) begin
            st_d.cnt = ld_val;
        end else if (tick_en) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/tick_cmp_flag.sv
module tick_cmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic upd_val,
    output logic dis
);
    typedef struct packed {
        logic dis;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.dis = upd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dis = st_q.dis;

endmodule

// File: rtl/tick_cmp_compare.sv
module tick_cmp_compare #(
    parameter int VAL_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_wr,
    input  logic [VAL_W-1:0] lim_val,
    input  logic             lim_dis,
    input  logic             dis_q,
    input  logic [VAL_W-1:0] cnt,
    output logic             fire,
    output logic             armed
);
    typedef struct packed {
        logic [VAL_W-1:0] cmp;
        logic             armed;
        logic             fire;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d    = st_q;
        hit     = st_q.armed && (cnt == st_q.cmp);
        // one-shot: a match always consumes the arming
        st_d.fire = hit && !dis_q;
        if (hit) begin
            st_d.armed = 1'b0;
        end
        // a compare write re-evaluates arming from scratch
        if (lim_wr) begin
            st_d.cmp   = lim_val;
            st_d.armed = (lim_val != '0) && !lim_dis;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire  = st_q.fire;
    assign armed = st_q.armed;

endmodule

// File: rtl/tick_cmp_route.sv
module tick_cmp_route #(
    parameter int KIND = 0
) (
    input  logic                         fire,
    output logic [tick_cmp_pkg::SI_W-1:0] softint_set
);
    import tick_cmp_pkg::*;

    generate
        if (KIND == KIND_TICK) begin : g_tick
            always_comb begin
                softint_set              = '0;
                softint_set[TICK_SI_IDX] = fire;
            end
        end else begin : g_stick
            always_comb begin
                softint_set               = '0;
                softint_set[STICK_SI_IDX] = fire;
            end
        end
    endgenerate

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
    parameter int DATA_W = 64,
    parameter int KIND   = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_en,
    input  logic                          wr_en,
    input  logic                          wr_sel,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DATA_W-1:0]             rd_data,
    output logic [tick_cmp_pkg::SI_W-1:0] softint_set
);
    import tick_cmp_pkg::*;

    localparam int VAL_W    = DATA_W - 1;
    localparam int CTRL_POS = DATA_W - 1;

    reg_sel_e         sel;
    logic             cnt_ld;
    logic             lim_wr;
    logic [VAL_W-1:0] wr_val;
    logic             wr_ctrl;
    logic [VAL_W-1:0] cnt;
    logic             dis;
    logic             fire;
    logic             armed;

    assign sel     = reg_sel_e'(wr_sel);
    assign wr_val  = wr_data[VAL_W-1:0];
    assign wr_ctrl = wr_data[CTRL_POS];
    assign cnt_ld  = wr_en && (sel == SEL_COUNT);
    assign lim_wr  = wr_en && (sel == SEL_LIMIT);

    tick_cmp_counter #(.VAL_W(VAL_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .ld_en   (cnt_ld),
        .ld_val  (wr_val),
        .cnt     (cnt)
    );

    tick_cmp_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (wr_en),
        .upd_val (wr_ctrl),
        .dis     (dis)
    );

    tick_cmp_compare #(.VAL_W(VAL_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .lim_wr  (lim_wr),
        .lim_val (wr_val),
        .lim_dis (wr_ctrl),
        .dis_q   (dis),
        .cnt     (cnt),
        .fire    (fire),
        .armed   (armed)
    );

    tick_cmp_route #(.KIND(KIND)) u_route (
        .fire        (fire),
        .softint_set (softint_set)
    );

    assign rd_data = {dis, cnt};

endmodule

// File: rtl/tick_cmp_chk.sv
module tick_cmp_chk #(
    parameter int DATA_W = 64,
    parameter int KIND   = 0
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tick_en,
    input logic                          wr_en,
    input logic                          wr_sel,
    input logic [DATA_W-1:0]             wr_data,
    input logic [DATA_W-1:0]             rd_data,
    input logic [tick_cmp_pkg::SI_W-1:0] softint_set
);
    import tick_cmp_pkg::*;

    localparam int VAL_W = DATA_W - 1;
    localparam int SEL_IDX = (KIND == KIND_TICK) ? TICK_SI_IDX : STICK_SI_IDX;
    localparam logic [SI_W-1:0] SEL_MASK = SI_W'(1) << SEL_IDX;

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick_en) |=> $stable(rd_data));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && tick_en) |=>
        (rd_data[VAL_W-1:0] == VAL_W'($past(rd_data[VAL_W-1:0]) + 1'b1)));

    // R2
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (rd_data == $past(wr_data)));

    // R5
    limit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (rd_data[DATA_W-1] == $past(wr_data[DATA_W-1])));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1] |=> (softint_set == '0));

    // R7
    route_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(softint_set) && ((softint_set & ~SEL_MASK) == '0));

endmodule

bind tick_cmp_timer tick_cmp_chk #(.DATA_W(DATA_W), .KIND(KIND)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .softint_set (softint_set)
);

// File: tb/sim_tick_cmp_timer.sv
`timescale 1ns/1ps
module sim_tick_cmp_timer;
    localparam int  DW  = 64;
    localparam int  SW  = 17;
    localparam real HP  = 4.0;
    localparam logic [DW-1:0] TOP = 64'h8000_0000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic wr_en = 1'b0;
    logic wr_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd0, rd1;
    logic [SW-1:0] si0, si1;

    int n_chk = 0;
    int n_fail = 0;

    always #(HP) clk = ~clk;

    tick_cmp_timer #(.DATA_W(DW), .KIND(0)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd0), .softint_set(si0)
    );

    tick_cmp_timer #(.DATA_W(DW), .KIND(1)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd1), .softint_set(si1)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; tick_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // tick n cycles, counting pulses of both instances
    task automatic run(input int n, output int seen0, output int seen1,
                       output logic [DW-1:0] at_cnt, output logic [SW-1:0] vec0,
                       output logic [SW-1:0] vec1);
        seen0 = 0; seen1 = 0; at_cnt = '0; vec0 = '0; vec1 = '0;
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            if (si0 != '0) begin seen0++; at_cnt = rd0; vec0 = si0; end
            if (si1 != '0) begin seen1++; vec1 = si1; end
        end
        tick_en = 1'b0;
    endtask

    task automatic main_seq();
        int s0, s1;
        logic [DW-1:0] at;
        logic [SW-1:0] v0, v1;
        logic [DW-1:0] exp;
        logic [DW-1:0] starts [3];

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(rd0 == '0, "R1 count after reset", rd0, '0);
        chk(si0 == '0 && si1 == '0, "R1 softint after reset", DW'(si0), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 count load, with and without control bit
        wr(1'b0, 64'd5);
        chk(rd0 == 64'd5, "R2 count load", rd0, 64'd5);
        wr(1'b0, TOP | 64'h1234);
        chk(rd0 == (TOP | 64'h1234), "R3 flag merged on read", rd0, TOP | 64'h1234);

        // R2 write beats increment in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 64'd77; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        chk(rd0 == 64'd77, "R2 load priority", rd0, 64'd77);

        // R4 increment sweep with irregular enable, including wrap
        starts[0] = 64'd0;
        starts[1] = TOP | 64'd1000;
        starts[2] = 64'h7FFF_FFFF_FFFF_FFF6;
        for (int k = 0; k < 3; k++) begin
            wr(1'b0, starts[k]);
            exp = starts[k];
            for (int i = 0; i < 24; i++) begin
                tick_en = ((i % 3) != 1) || (k == 2);
                if (tick_en) exp = {exp[DW-1], exp[DW-2:0] + 63'd1};
                @(negedge clk);
                chk(rd0 == exp, "R4 count sweep", rd0, exp);
            end
            tick_en = 1'b0;
        end

        // R4 hold without enable
        exp = rd0;
        repeat (5) @(negedge clk);
        chk(rd0 == exp, "R4 hold", rd0, exp);

        // R6 R7 match sweep over compare values
        for (int L = 1; L <= 8; L++) begin
            wr(1'b0, 64'd0);
            wr(1'b1, 64'(L));
            run(L + 8, s0, s1, at, v0, v1);
            chk(s0 == 1, "R6 single pulse", 64'(s0), 64'd1);
            chk(at == 64'(L + 1), "R6 pulse timing", at, 64'(L + 1));
            chk(v0 == 17'h00001, "R7 tick bit", DW'(v0), 64'h1);
            chk(s1 == 1 && v1 == 17'h10000, "R7 system tick bit", DW'(v1), 64'h10000);
        end

        // R8 zero compare arms nothing
        wr(1'b0, 64'd0);
        wr(1'b1, 64'd0);
        run(20, s0, s1, at, v0, v1);
        chk(s0 == 0, "R8 zero compare", 64'(s0), 64'd0);

        // R8 zero compare cancels pending
        wr(1'b0, 64'd0);
        wr(1'b1, 64'd12);
        run(4, s0, s1, at, v0, v1);
        wr(1'b1, 64'd0);
        run(20, s0, s1, at, v0, v1);
        chk(s0 == 0, "R8 cancel pending", 64'(s0), 64'd0);

        // R9 disabled compare write cancels pending
        wr(1'b0, 64'd0);
        wr(1'b1, 64'd10);
        wr(1'b1, TOP | 64'd10);
        chk(rd0[DW-1] == 1'b1, "R5 flag from compare write", rd0, rd0 | TOP);
        wr(1'b0, 64'd0);
        run(20, s0, s1, at, v0, v1);
        chk(s0 == 0, "R9 disabled compare", 64'(s0), 64'd0);

        // R10 match while disabled is silent and consumes arming
        wr(1'b0, 64'd0);
        wr(1'b1, 64'd15);
        wr(1'b0, TOP | 64'd0);
        run(25, s0, s1, at, v0, v1);
        chk(s0 == 0, "R10 silent match", 64'(s0), 64'd0);
        wr(1'b0, 64'd0);
        run(25, s0, s1, at, v0, v1);
        chk(s0 == 0, "R10 arming consumed", 64'(s0), 64'd0);

        // R1 reset while armed
        wr(1'b0, 64'd0);
        wr(1'b1, 64'd6);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(rd0 == '0, "R1 count after mid reset", rd0, '0);
        run(20, s0, s1, at, v0, v1);
        chk(s0 == 0, "R1 arming cleared by reset", 64'(s0), 64'd0);
    endtask

    initial begin
        fork
            main_seq();
            begin
                #(8 * 150000);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule